// File: doc/BRIEF.md
# Accumulator Load Operand Resolver

This block carries out the operand side of an accumulator load. A request gives a 3-bit mode code, a 16-bit address field, the current program counter and a base-register selector. The unit works out where the operand lives, fetches it, writes it into the accumulator and reports the effective address it used. The operand can come from the address field itself, from a small internal bank of sixteen registers, or from an external single-port data memory with one cycle of read latency. One `done` pulse marks completion.

Seven modes are handled:

- immediate, where the field is the value;
- direct;
- memory indirect, which makes two chained reads through the same memory port;
- register direct;
- register indirect, where the named register holds the number of a second register;
- PC-relative;
- indexed.

Code 7 is reserved. It completes with an error flag set. The register bank is loaded through its own synchronous write port.

Top module: `opnd_fetch_unit`

## Requirements
- R1: Immediate (mode 0): the accumulator takes the address field. The effective address reads 0. No memory read is made. `done` rises 2 cycles after the start edge.
- R2: Direct (mode 1): exactly one memory read, at the address field. The accumulator takes that word. The effective address is the address field. Latency is 3 cycles.
- R3: Memory indirect (mode 2): the word at the address field is used as a second address, and the operand is read from that second address. This makes two memory reads. The effective address is the second address. Latency is 4 cycles.
- R4: Register direct (mode 3): the operand is the register numbered by the low 4 bits of the address field, and the upper bits are ignored. The effective address is that register number. No memory read is made. Latency is 2 cycles.
- R5: Register indirect (mode 4): the low 4 bits of the named register pick a second register, and that second register is the operand. The effective address is the second register number. No memory read is made. Latency is 2 cycles.
- R6: PC-relative (mode 5): the effective address is the program counter plus the address field, modulo 2^16. One memory read is made at that address. Latency is 3 cycles.
- R7: Indexed (mode 6): the effective address is the content of the register picked by the base selector plus the address field, modulo 2^16. One memory read is made at that address. Latency is 3 cycles.
- R8: `done` is a single-cycle pulse. The accumulator and the effective-address outputs change only in the cycle `done` is high.
- R9: `start` is accepted only while `busy` is low. A start seen while busy has no effect on the running operation or on the outputs.
- R10: Mode code 7 completes after 2 cycles with `err` high. The accumulator and the effective address are left unchanged. The next valid completion clears `err`.
- R11: During reset the accumulator, effective address, `done`, `err`, `busy` and `mem_re` are all 0.
- R12: A register write (`rf_we`) takes effect at the next clock edge, and a later fetch returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| mode | input | 3 | Addressing mode code |
| afield | input | 16 | Address field / constant operand |
| pc | input | 16 | Program counter for PC-relative mode |
| base_sel | input | 4 | Base register for indexed mode |
| rf_we | input | 1 | Register bank write enable |
| rf_waddr | input | 4 | Register bank write index |
| rf_wdata | input | 16 | Register bank write data |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the strobe |
| acc | output | 16 | Accumulator |
| eff_addr | output | 16 | Effective address of the last good completion |
| done | output | 1 | Completion pulse |
| err | output | 1 | Last completion used the reserved mode |
| busy | output | 1 | Operation in progress |

## Verification
The bench uses the default build: a 16-bit data width and sixteen registers. With these values, address sums that pass 0xFFFF can be checked for wrap-around. A register-direct field with bits set above bit 3 tests that the upper selector bits are ignored. The bench memory decodes 256 words, which holds the word table and the pointer chains used by indirect mode. Every fetch is also checked for its cycle count and its number of memory strobes, so each mode's read path is pinned down as well as its result.

// File: rtl/opf_pkg.sv
package opf_pkg;
    typedef enum logic [2:0] {
        M_IMM   = 3'd0,
        M_DIR   = 3'd1,
        M_MIND  = 3'd2,
        M_RDIR  = 3'd3,
        M_RIND  = 3'd4,
        M_PCREL = 3'd5,
        M_IDX   = 3'd6,
        M_RSVD  = 3'd7
    } opf_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DISP,
        S_RD1,
        S_RD2
    } opf_state_e;
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RSW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RSW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RSW-1:0] ra_addr,
    output logic [DW-1:0]  ra_data,
    input  logic [RSW-1:0] rb_addr,
    output logic [DW-1:0]  rb_data
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == RSW'(g))
                regs[g] <= wdata;
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];
endmodule

// File: rtl/opf_ea_gen.sv
module opf_ea_gen
    import opf_pkg::*;
#(
    parameter int DW = 16
) (
    input  opf_mode_e     mode,
    input  logic [DW-1:0] afield,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] base_val,
    output logic [DW-1:0] ea,
    output logic          is_mem
);
    always_comb begin
        ea     = afield;
        is_mem = 1'b0;
        unique case (mode)
            M_DIR, M_MIND: begin
                ea     = afield;
                is_mem = 1'b1;
            end
            M_PCREL: begin
                ea     = pc + afield;
                is_mem = 1'b1;
            end
            M_IDX: begin
                ea     = base_val + afield;
                is_mem = 1'b1;
            end
            default: begin
                ea     = afield;
                is_mem = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
    import opf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RSW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [DW-1:0]  afield,
    input  logic [DW-1:0]  pc,
    input  logic [RSW-1:0] base_sel,
    input  logic           rf_we,
    input  logic [RSW-1:0] rf_waddr,
    input  logic [DW-1:0]  rf_wdata,
    output logic           mem_re,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  acc,
    output logic [DW-1:0]  eff_addr,
    output logic           done,
    output logic           err,
    output logic           busy
);
    typedef struct packed {
        opf_state_e     st;
        opf_mode_e      md;
        logic [DW-1:0]  af;
        logic [DW-1:0]  pc;
        logic [RSW-1:0] base;
        logic [DW-1:0]  ptr;
        logic [DW-1:0]  acc;
        logic [DW-1:0]  ea;
        logic           done;
        logic           err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [RSW-1:0] ra_addr;
    logic [DW-1:0]  ra_data, rb_data;
    logic [DW-1:0]  ea_calc;
    logic           ea_is_mem;

    assign ra_addr = (ctx_q.md == M_IDX) ? ctx_q.base : ctx_q.af[RSW-1:0];

    opf_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (ra_data[RSW-1:0]),
        .rb_data (rb_data)
    );

    opf_ea_gen #(.DW(DW)) u_ea (
        .mode     (ctx_q.md),
        .afield   (ctx_q.af),
        .pc       (ctx_q.pc),
        .base_val (ra_data),
        .ea       (ea_calc),
        .is_mem   (ea_is_mem)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (start) begin
                    ctx_d.st   = S_DISP;
                    ctx_d.md   = opf_mode_e'(mode);
                    ctx_d.af   = afield;
                    ctx_d.pc   = pc;
                    ctx_d.base = base_sel;
                end
            end
            S_DISP: begin
                if (ea_is_mem) begin
                    ctx_d.st  = S_RD1;
                    ctx_d.ptr = ea_calc;
                end else begin
                    ctx_d.st   = S_IDLE;
                    ctx_d.done = 1'b1;
                    ctx_d.err  = 1'b0;
                    unique case (ctx_q.md)
                        M_IMM: begin
                            ctx_d.acc = ctx_q.af;
                            ctx_d.ea  = '0;
                        end
                        M_RDIR: begin
                            ctx_d.acc = ra_data;
                            ctx_d.ea  = {{(DW-RSW){1'b0}}, ctx_q.af[RSW-1:0]};
                        end
                        M_RIND: begin
                            ctx_d.acc = rb_data;
                            ctx_d.ea  = {{(DW-RSW){1'b0}}, ra_data[RSW-1:0]};
                        end
                        default: ctx_d.err = 1'b1;
                    endcase
                end
            end
            S_RD1: begin
                if (ctx_q.md == M_MIND) begin
                    ctx_d.st  = S_RD2;
                    ctx_d.ptr = mem_rdata;
                end else begin
                    ctx_d.st   = S_IDLE;
                    ctx_d.done = 1'b1;
                    ctx_d.err  = 1'b0;
                    ctx_d.acc  = mem_rdata;
                    ctx_d.ea   = ctx_q.ptr;
                end
            end
            S_RD2: begin
                ctx_d.st   = S_IDLE;
                ctx_d.done = 1'b1;
                ctx_d.err  = 1'b0;
                ctx_d.acc  = mem_rdata;
                ctx_d.ea   = ctx_q.ptr;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= S_IDLE;
            ctx_q.md <= M_IMM;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_re   = (ctx_q.st == S_DISP && ea_is_mem) ||
                      (ctx_q.st == S_RD1 && ctx_q.md == M_MIND);
    assign mem_addr = (ctx_q.st == S_RD1) ? mem_rdata : ea_calc;
    assign acc      = ctx_q.acc;
    assign eff_addr = ctx_q.ea;
    assign done     = ctx_q.done;
    assign err      = ctx_q.err;
    assign busy     = (ctx_q.st != S_IDLE);
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          busy,
    input logic          mem_re,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] eff_addr
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(acc));

    a_r8_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(eff_addr));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_err_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(acc) && $stable(eff_addr)));

    a_r9_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_re);
endmodule

bind opnd_fetch_unit opf_checker #(.DW(DW)) u_opf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err      (err),
    .busy     (busy),
    .mem_re   (mem_re),
    .acc      (acc),
    .eff_addr (eff_addr)
);

// File: tb/tb_opnd_fetch_unit.sv
module tb_opnd_fetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] afield = '0;
    logic [15:0] pc = '0;
    logic [3:0]  base_sel = '0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_waddr = '0;
    logic [15:0] rf_wdata = '0;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] acc, eff_addr;
    logic        done, err, busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int lat, reads;
    bit stable_ok;
    logic [15:0] mem [256];

    always #5 clk = ~clk;

    opnd_fetch_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
        .pc(pc), .base_sel(base_sel), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .acc(acc), .eff_addr(eff_addr), .done(done),
        .err(err), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [15:0] val);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = idx; rf_wdata = val;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] m, input logic [15:0] a, input logic [15:0] p, input logic [3:0] b);
        logic [15:0] prev;
        @(negedge clk);
        mode = m; afield = a; pc = p; base_sel = b; start = 1'b1;
        prev = acc; lat = 0; reads = 0; stable_ok = 1'b1;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (mem_re) reads++;
            if (!done && acc !== prev) stable_ok = 1'b0;
        end while (!done && lat < 15);
    endtask

    typedef struct packed {
        logic [2:0]  md;
        logic [15:0] af;
        logic [15:0] pcv;
        logic [3:0]  bs;
        logic [15:0] exp_acc;
        logic [15:0] exp_ea;
        logic [3:0]  exp_lat;
        logic [1:0]  exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'd16,     16'd0,    4'd0, 16'd16,     16'd0,  4'd2, 2'd0, 4'd1},  // R1
        '{3'd1, 16'd16,     16'd0,    4'd0, 16'd22,     16'd16, 4'd3, 2'd1, 4'd2},  // R2
        '{3'd2, 16'd16,     16'd0,    4'd0, 16'd28,     16'd22, 4'd4, 2'd2, 4'd3},  // R3
        '{3'd2, 16'd18,     16'd0,    4'd0, 16'd30,     16'd24, 4'd4, 2'd2, 4'd3},  // R3
        '{3'd3, 16'd7,      16'd0,    4'd0, 16'h0A07,   16'd7,  4'd2, 2'd0, 4'd4},  // R4
        '{3'd3, 16'h0015,   16'd0,    4'd0, 16'h0A05,   16'd5,  4'd2, 2'd0, 4'd4},  // R4 upper bits ignored
        '{3'd4, 16'd15,     16'd0,    4'd0, 16'h0A0A,   16'd10, 4'd2, 2'd0, 4'd5},  // R5
        '{3'd4, 16'd3,      16'd0,    4'd0, 16'h0A05,   16'd5,  4'd2, 2'd0, 4'd5},  // R5
        '{3'd5, 16'd6,      16'd20,   4'd0, 16'd32,     16'd26, 4'd3, 2'd1, 4'd6},  // R6
        '{3'd5, 16'hFFFE,   16'h0010, 4'd0, 16'h1234,   16'd14, 4'd3, 2'd1, 4'd6},  // R6 wrap
        '{3'd6, 16'd4,      16'd0,    4'd2, 16'd30,     16'd24, 4'd3, 2'd1, 4'd7},  // R7
        '{3'd6, 16'hF600,   16'd0,    4'd7, 16'h0777,   16'd7,  4'd3, 2'd1, 4'd7},  // R7 wrap
        '{3'd0, 16'hFFFF,   16'd0,    4'd0, 16'hFFFF,   16'd0,  4'd2, 2'd0, 4'd1}   // R1
    };

    initial begin
        string rq;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 16; i <= 28; i += 2) mem[i] = 16'(i + 6);
        mem[14] = 16'h1234;
        mem[7]  = 16'h0777;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "acc", acc, 0);
        chk("R11", "eff_addr", eff_addr, 0);
        chk("R11", "done/err/busy/mem_re", {done, err, busy, mem_re}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++)
            wr_reg(4'(i), (i == 15) ? 16'd10 : (i == 2) ? 16'd20 :
                          (i == 3) ? 16'd5 : 16'(16'h0A00 + i));

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].md, VECS[v].af, VECS[v].pcv, VECS[v].bs);
            rq = $sformatf("R%0d", VECS[v].req);
            chk(rq, "acc", acc, VECS[v].exp_acc);
            chk(rq, "eff_addr", eff_addr, VECS[v].exp_ea);
            chk(rq, "latency", lat, VECS[v].exp_lat);
            chk(rq, "mem reads", reads, VECS[v].exp_rd);
            chk(rq, "err", err, 0);
            chk("R8", "acc stable before done", stable_ok, 1);
            @(negedge clk);
            chk("R8", "done one cycle", done, 0);
        end

        // R10: reserved mode keeps acc and eff_addr, sets err
        run_op(3'd7, 16'h0055, 16'd0, 4'd0);
        chk("R10", "acc kept", acc, 16'hFFFF);
        chk("R10", "eff_addr kept", eff_addr, 16'd0);
        chk("R10", "err", err, 1);
        chk("R10", "latency", lat, 2);
        run_op(3'd1, 16'd20, 16'd0, 4'd0);
        chk("R10", "err cleared", err, 0);
        chk("R2", "acc", acc, 16'd26);

        // R9: start while busy is ignored
        run_op(3'd2, 16'd16, 16'd0, 4'd0);
        begin
            int dones;
            dones = 0;
            @(negedge clk);
            mode = 3'd0; afield = 16'd99; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            run_op(3'd2, 16'd20, 16'd0, 4'd0);
            chk("R3", "indirect 20 acc", acc, 16'd32);
            chk("R3", "indirect 20 ea", eff_addr, 16'd26);
            @(negedge clk);
            mode = 3'd2; afield = 16'd16; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            mode = 3'd0; afield = 16'd99; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 8; k++) begin
                if (done) dones++;
                @(negedge clk);
            end
            chk("R9", "single completion", dones, 1);
            chk("R9", "acc from running op", acc, 16'd28);
            chk("R9", "ea from running op", eff_addr, 16'd22);
        end

        // R12: register write visible to the next fetch
        wr_reg(4'd4, 16'hBEEF);
        run_op(3'd3, 16'd4, 16'd0, 4'd0);
        chk("R12", "new register value", acc, 16'hBEEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule